// File: doc/BRIEF.md
# Translation Table Maintenance Registers

This block holds the 64-slot translation table and the registers that system software uses to maintain it. There are four registers. The entry-high register holds a virtual page number and the current process ID. The entry-low register holds a frame number and the attribute flags. The slot-select register names one table slot and carries a probe-failure flag. The replacement counter is a free-running down-counter that never points into the lowest reserved slots. A single register port serves move-to and move-from accesses.

Four single-cycle command strobes act on the table. A lookup searches every slot for the entry-high contents. A fetch copies the selected slot into the two entry registers. A selected store and a replacement store copy the entry registers into a slot. The translation datapath sees the table through three paths: a write port, a plain read port and an associative compare that uses the current process ID held in entry-high.

Each cycle, command decode picks one operation, named CMD_IDLE, CMD_LOOKUP, CMD_FETCH, CMD_STORE_SEL or CMD_STORE_REPL. The replacement counter is a cyclic state sequence. It starts at state 63, steps down one state per clock through 62 … 8, and returns from state 8 to state 63.

Top module: `tlb_maint_unit`

## Requirements
- R1: After reset the slot-select register reads 0 with its failure flag clear, the replacement counter reads 63, both entry registers read 0 and every table slot holds zero in both halves.
- R2: The replacement counter decreases by one on every clock, goes from 8 to 63, and never holds a value below 8.
- R3: Register port encoding: reg_sel 0 is slot-select, 1 is the replacement counter, 2 is entry-low and 3 is entry-high. Entry-high and entry-low take all 32 written bits. A write to slot-select loads only bits 5:0 and leaves the failure flag as it was. Its readback is the failure flag in bit 31, zeros in bits 30:6 and the slot number in bits 5:0. Writes to the replacement counter have no effect.
- R4: A selected store writes entry-high and entry-low into the slot named by slot-select bits 5:0. The result is visible on the translator read port after that clock.
- R5: A replacement store writes the entry registers into the slot that the replacement counter names in the cycle of the strobe.
- R6: A slot matches a lookup when its high-word bits 31:12 (page number) equal those of entry-high, and either its bits 11:6 (process ID) equal those of entry-high or bit 8 (global) of its low word is set. On a successful lookup, slot-select takes the lowest matching slot number and the failure flag clears.
- R7: A lookup with no matching slot sets the failure flag in bit 31 of slot-select and leaves bits 5:0 unchanged.
- R8: A fetch loads entry-high and entry-low from the slot named by slot-select.
- R9: When several strobes are active in one cycle, only one command runs. Lookup goes first, then fetch, then selected store, then replacement store.
- R10: When a register-port write and a command update the same register in one cycle, the command's value is kept.
- R11: The associative compare reports a hit, the lowest matching slot and that slot's low word for xl_vpn, using the R6 rule with the process ID in entry-high bits 11:6 (also driven on cur_pid).
- R12: The translator write port stores into a slot, except in a cycle where a store command runs; that translator write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register port write enable |
| reg_sel | input | 2 | Register select (0 slot-select, 1 counter, 2 entry-low, 3 entry-high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| cmd_lookup | input | 1 | Lookup strobe |
| cmd_fetch | input | 1 | Fetch strobe |
| cmd_store_sel | input | 1 | Selected store strobe |
| cmd_store_repl | input | 1 | Replacement store strobe |
| cur_pid | output | 6 | Current process ID |
| xl_wr_en | input | 1 | Translator write enable |
| xl_wr_slot | input | 6 | Translator write slot |
| xl_wr_hi | input | 32 | Translator write high word |
| xl_wr_lo | input | 32 | Translator write low word |
| xl_rd_slot | input | 6 | Translator read slot |
| xl_rd_hi | output | 32 | High word of xl_rd_slot |
| xl_rd_lo | output | 32 | Low word of xl_rd_slot |
| xl_vpn | input | 20 | Page number to compare |
| xl_hit | output | 1 | Compare hit |
| xl_hit_slot | output | 6 | Lowest matching slot |
| xl_hit_lo | output | 32 | Low word of the matching slot |

## Verification
Lookups run from a vector table against a preloaded set of slots. Two slots share a page number but carry different process IDs, which shows that the ID takes part in the match. A global slot is hit under an unrelated ID, which shows that the global bit bypasses the ID check. A global slot and an exact slot both match one key, which shows that the lowest slot wins. Two misses are placed after hits, which shows that the slot field is kept while the flag is set. A final hit shows that the flag clears again. Strobe combinations are run with entry registers and slots arranged so that each command that should not run would leave a visible mark. Over a long run the counter's step, wrap and floor are checked, and replacement stores go to the slot that was read just before the strobe.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam int WORD_W  = 32;
    localparam int VPN_LSB = 12;
    localparam int VPN_W   = 20;
    localparam int PID_LSB = 6;
    localparam int PID_W   = 6;
    localparam int GLB_BIT = 8;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_LOOKUP,
        CMD_FETCH,
        CMD_STORE_SEL,
        CMD_STORE_REPL
    } tlbm_cmd_e;

    typedef enum logic [1:0] {
        SEL_SLOT = 2'd0,
        SEL_REPL = 2'd1,
        SEL_LO   = 2'd2,
        SEL_HI   = 2'd3
    } tlbm_sel_e;

    function automatic logic slot_match(input logic [WORD_W-1:0] hi,
                                        input logic [WORD_W-1:0] lo,
                                        input logic [VPN_W-1:0]  vpn,
                                        input logic [PID_W-1:0]  pid);
        logic vpn_eq;
        logic pid_ok;
        vpn_eq = (hi[VPN_LSB +: VPN_W] == vpn);
        pid_ok = (hi[PID_LSB +: PID_W] == pid) || lo[GLB_BIT];
        return vpn_eq && pid_ok;
    endfunction
endpackage

// File: rtl/tlbm_repl_ctr.sv
module tlbm_repl_ctr #(
    parameter  int SLOTS = 64,
    parameter  int RESV  = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] repl
);
    localparam logic [IDX_W-1:0] TOP   = IDX_W'(SLOTS - 1);
    localparam logic [IDX_W-1:0] FLOOR = IDX_W'(RESV);

    always_ff @(posedge clk) begin
        if (!rst_n)
            repl <= TOP;
        else if (repl == FLOOR)
            repl <= TOP;
        else
            repl <= repl - 1'b1;
    end

    assert_repl_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        repl >= FLOOR);

    assert_repl_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> repl != $past(repl));
endmodule

// File: rtl/tlbm_table.sv
module tlbm_table
    import tlbm_pkg::*;
#(
    parameter  int SLOTS = 64,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wslot,
    input  logic [WORD_W-1:0] whi,
    input  logic [WORD_W-1:0] wlo,
    input  logic [IDX_W-1:0]  cslot,
    output logic [WORD_W-1:0] chi,
    output logic [WORD_W-1:0] clo,
    input  logic [IDX_W-1:0]  xslot,
    output logic [WORD_W-1:0] xhi,
    output logic [WORD_W-1:0] xlo,
    input  logic [WORD_W-1:0] key_hi,
    output logic              p_hit,
    output logic [IDX_W-1:0]  p_slot,
    input  logic [VPN_W-1:0]  x_vpn,
    input  logic [PID_W-1:0]  x_pid,
    output logic              x_hit,
    output logic [IDX_W-1:0]  x_slot,
    output logic [WORD_W-1:0] x_lo
);
    logic [WORD_W-1:0] mem_hi [SLOTS];
    logic [WORD_W-1:0] mem_lo [SLOTS];
    logic [SLOTS-1:0]  p_vec;
    logic [SLOTS-1:0]  x_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                mem_hi[s] <= '0;
                mem_lo[s] <= '0;
            end
        end else if (we) begin
            mem_hi[wslot] <= whi;
            mem_lo[wslot] <= wlo;
        end
    end

    assign chi = mem_hi[cslot];
    assign clo = mem_lo[cslot];
    assign xhi = mem_hi[xslot];
    assign xlo = mem_lo[xslot];

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign p_vec[g] = slot_match(mem_hi[g], mem_lo[g],
                                     key_hi[VPN_LSB +: VPN_W],
                                     key_hi[PID_LSB +: PID_W]);
        assign x_vec[g] = slot_match(mem_hi[g], mem_lo[g], x_vpn, x_pid);
    end

    always_comb begin
        p_slot = '0;
        x_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (p_vec[i]) p_slot = IDX_W'(i);
            if (x_vec[i]) x_slot = IDX_W'(i);
        end
    end

    assign p_hit = |p_vec;
    assign x_hit = |x_vec;
    assign x_lo  = mem_lo[x_slot];

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_hi[$past(wslot)] == $past(whi)) && (mem_lo[$past(wslot)] == $past(wlo)));
endmodule

// File: rtl/tlb_maint_unit.sv
module tlb_maint_unit
    import tlbm_pkg::*;
#(
    parameter  int SLOTS = 64,
    parameter  int RESV  = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cmd_lookup,
    input  logic              cmd_fetch,
    input  logic              cmd_store_sel,
    input  logic              cmd_store_repl,
    output logic [5:0]        cur_pid,
    input  logic              xl_wr_en,
    input  logic [IDX_W-1:0]  xl_wr_slot,
    input  logic [31:0]       xl_wr_hi,
    input  logic [31:0]       xl_wr_lo,
    input  logic [IDX_W-1:0]  xl_rd_slot,
    output logic [31:0]       xl_rd_hi,
    output logic [31:0]       xl_rd_lo,
    input  logic [19:0]       xl_vpn,
    output logic              xl_hit,
    output logic [IDX_W-1:0]  xl_hit_slot,
    output logic [31:0]       xl_hit_lo
);
    localparam int PAD_W = WORD_W - 1 - IDX_W;

    tlbm_cmd_e         cmd;
    tlbm_sel_e         sel;
    logic [WORD_W-1:0] ent_hi;
    logic [WORD_W-1:0] ent_lo;
    logic [IDX_W-1:0]  slot_sel;
    logic              lookup_fail;
    logic [IDX_W-1:0]  repl;

    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_slot;
    logic [WORD_W-1:0] tbl_hi;
    logic [WORD_W-1:0] tbl_lo;
    logic [WORD_W-1:0] cur_hi;
    logic [WORD_W-1:0] cur_lo;
    logic              p_hit;
    logic [IDX_W-1:0]  p_slot;

    assign sel = tlbm_sel_e'(reg_sel);

    always_comb begin
        if (cmd_lookup)          cmd = CMD_LOOKUP;
        else if (cmd_fetch)      cmd = CMD_FETCH;
        else if (cmd_store_sel)  cmd = CMD_STORE_SEL;
        else if (cmd_store_repl) cmd = CMD_STORE_REPL;
        else                     cmd = CMD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_hi      <= '0;
            ent_lo      <= '0;
            slot_sel    <= '0;
            lookup_fail <= 1'b0;
        end else begin
            if (reg_we) begin
                unique case (sel)
                    SEL_SLOT: slot_sel <= reg_wdata[IDX_W-1:0];
                    SEL_REPL: ;
                    SEL_LO:   ent_lo   <= reg_wdata;
                    SEL_HI:   ent_hi   <= reg_wdata;
                endcase
            end
            unique case (cmd)
                CMD_LOOKUP: begin
                    if (p_hit) begin
                        slot_sel    <= p_slot;
                        lookup_fail <= 1'b0;
                    end else begin
                        slot_sel    <= slot_sel;
                        lookup_fail <= 1'b1;
                    end
                end
                CMD_FETCH: begin
                    ent_hi <= cur_hi;
                    ent_lo <= cur_lo;
                end
                CMD_IDLE, CMD_STORE_SEL, CMD_STORE_REPL: ;
            endcase
        end
    end

    always_comb begin
        tbl_we   = 1'b0;
        tbl_slot = xl_wr_slot;
        tbl_hi   = xl_wr_hi;
        tbl_lo   = xl_wr_lo;
        unique case (cmd)
            CMD_STORE_SEL: begin
                tbl_we   = 1'b1;
                tbl_slot = slot_sel;
                tbl_hi   = ent_hi;
                tbl_lo   = ent_lo;
            end
            CMD_STORE_REPL: begin
                tbl_we   = 1'b1;
                tbl_slot = repl;
                tbl_hi   = ent_hi;
                tbl_lo   = ent_lo;
            end
            CMD_IDLE, CMD_LOOKUP, CMD_FETCH: tbl_we = xl_wr_en;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_SLOT: reg_rdata = {lookup_fail, {PAD_W{1'b0}}, slot_sel};
            SEL_REPL: reg_rdata = {{(WORD_W-IDX_W){1'b0}}, repl};
            SEL_LO:   reg_rdata = ent_lo;
            SEL_HI:   reg_rdata = ent_hi;
        endcase
    end

    assign cur_pid = ent_hi[PID_LSB +: PID_W];

    tlbm_repl_ctr #(.SLOTS(SLOTS), .RESV(RESV)) u_repl (
        .clk  (clk),
        .rst_n(rst_n),
        .repl (repl)
    );

    tlbm_table #(.SLOTS(SLOTS)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .wslot (tbl_slot),
        .whi   (tbl_hi),
        .wlo   (tbl_lo),
        .cslot (slot_sel),
        .chi   (cur_hi),
        .clo   (cur_lo),
        .xslot (xl_rd_slot),
        .xhi   (xl_rd_hi),
        .xlo   (xl_rd_lo),
        .key_hi(ent_hi),
        .p_hit (p_hit),
        .p_slot(p_slot),
        .x_vpn (xl_vpn),
        .x_pid (cur_pid),
        .x_hit (xl_hit),
        .x_slot(xl_hit_slot),
        .x_lo  (xl_hit_lo)
    );

    assert_lookup_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lookup && p_hit) |=> (!lookup_fail && slot_sel == $past(p_slot)));

    assert_lookup_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lookup && !p_hit) |=> (lookup_fail && $stable(slot_sel)));

    assert_fetch_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fetch && !cmd_lookup) |=> (ent_hi == $past(cur_hi) && ent_lo == $past(cur_lo)));

    assert_repl_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STORE_REPL) |-> (tbl_we && tbl_slot >= IDX_W'(RESV)));

    assert_lookup_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lookup |-> !(tbl_we && !xl_wr_en));
endmodule

// File: tb/tlb_maint_unit_tb.sv
`timescale 1ns/1ps
module tlb_maint_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_lookup = 1'b0, cmd_fetch = 1'b0, cmd_store_sel = 1'b0, cmd_store_repl = 1'b0;
    logic [5:0]  cur_pid;
    logic        xl_wr_en = 1'b0;
    logic [5:0]  xl_wr_slot = '0;
    logic [31:0] xl_wr_hi = '0, xl_wr_lo = '0;
    logic [5:0]  xl_rd_slot = '0;
    logic [31:0] xl_rd_hi, xl_rd_lo;
    logic [19:0] xl_vpn = '0;
    logic        xl_hit;
    logic [5:0]  xl_hit_slot;
    logic [31:0] xl_hit_lo;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    tlb_maint_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_lookup(cmd_lookup), .cmd_fetch(cmd_fetch),
        .cmd_store_sel(cmd_store_sel), .cmd_store_repl(cmd_store_repl),
        .cur_pid(cur_pid), .xl_wr_en(xl_wr_en), .xl_wr_slot(xl_wr_slot),
        .xl_wr_hi(xl_wr_hi), .xl_wr_lo(xl_wr_lo), .xl_rd_slot(xl_rd_slot),
        .xl_rd_hi(xl_rd_hi), .xl_rd_lo(xl_rd_lo), .xl_vpn(xl_vpn),
        .xl_hit(xl_hit), .xl_hit_slot(xl_hit_slot), .xl_hit_lo(xl_hit_lo)
    );

    localparam logic [1:0] R_SLOT = 2'd0, R_REPL = 2'd1, R_LO = 2'd2, R_HI = 2'd3;

    // lookup vectors: {vpn, pid, expected slot-select readback}
    localparam logic [57:0] LVEC [7] = '{
        {20'h12345, 6'd3,  32'h0000000A},
        {20'h12345, 6'd7,  32'h0000001E},
        {20'h12345, 6'd4,  32'h8000001E},
        {20'h0BEEF, 6'd33, 32'h00000014},
        {20'h0BEEF, 6'd9,  32'h00000014},
        {20'h55555, 6'd3,  32'h80000014},
        {20'h12345, 6'd3,  32'h0000000A}
    };

    function automatic logic [31:0] mk_hi(input logic [19:0] vpn, input logic [5:0] pid);
        return {vpn, pid, 6'b0};
    endfunction

    function automatic logic [31:0] mk_lo(input logic [19:0] pfn, input logic [3:0] flags);
        return {pfn, flags, 8'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic cmd(input logic lk, input logic fe, input logic ss, input logic sr);
        cmd_lookup = lk; cmd_fetch = fe; cmd_store_sel = ss; cmd_store_repl = sr;
        @(negedge clk);
        cmd_lookup = 0; cmd_fetch = 0; cmd_store_sel = 0; cmd_store_repl = 0;
    endtask

    task automatic load(input logic [5:0] slot, input logic [31:0] hi, input logic [31:0] lo);
        wr_reg(R_SLOT, {26'b0, slot});
        wr_reg(R_HI, hi);
        wr_reg(R_LO, lo);
        cmd(0, 0, 1, 0);
    endtask

    task automatic peek(input logic [5:0] slot, output logic [31:0] hi, output logic [31:0] lo);
        xl_rd_slot = slot;
        #1;
        hi = xl_rd_hi;
        lo = xl_rd_lo;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h, l, h0, l0;
        logic [5:0]  r, rp;
        logic        saw_wrap;

        // R1 reset state
        repeat (3) @(negedge clk);
        rd_reg(R_SLOT, v); chk("R1 slot-select", v, 32'h0);
        rd_reg(R_REPL, v); chk("R1 counter", v, 32'd63);
        rd_reg(R_HI, v);   chk("R1 entry-high", v, 32'h0);
        rd_reg(R_LO, v);   chk("R1 entry-low", v, 32'h0);
        peek(6'd37, h, l); chk("R1 slot hi", h, 32'h0); chk("R1 slot lo", l, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 counter sequence
        rd_reg(R_REPL, v); rp = v[5:0];
        saw_wrap = 0;
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            rd_reg(R_REPL, v); r = v[5:0];
            chk("R2 counter step", {26'b0, r}, (rp == 6'd8) ? 32'd63 : {26'b0, rp - 6'd1});
            if (r < 6'd8) chk("R2 counter floor", {26'b0, r}, 32'd8);
            if (rp == 6'd8) saw_wrap = 1;
            rp = r;
        end
        chk("R2 wrap seen", {31'b0, saw_wrap}, 32'd1);

        // R3 register port
        wr_reg(R_HI, 32'hA5A5_5A5A); rd_reg(R_HI, v); chk("R3 entry-high", v, 32'hA5A5_5A5A);
        wr_reg(R_LO, 32'h1234_FFFF); rd_reg(R_LO, v); chk("R3 entry-low", v, 32'h1234_FFFF);
        wr_reg(R_SLOT, 32'hFFFF_FFFF); rd_reg(R_SLOT, v); chk("R3 slot-select field only", v, 32'h0000_003F);
        rd_reg(R_REPL, v); rp = v[5:0];
        reg_we = 1'b1; reg_sel = R_REPL; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0;
        rd_reg(R_REPL, v);
        chk("R3 counter write ignored", v, (rp == 6'd8) ? 32'd63 : {26'b0, rp - 6'd1});

        // R4 preload via selected store
        load(6'd10, mk_hi(20'h12345, 6'd3), mk_lo(20'hAAAAA, 4'b0110));
        load(6'd20, mk_hi(20'h0BEEF, 6'd5), mk_lo(20'hBBBBB, 4'b0011));
        load(6'd30, mk_hi(20'h12345, 6'd7), mk_lo(20'hCCCCC, 4'b1010));
        load(6'd40, mk_hi(20'h0BEEF, 6'd9), mk_lo(20'hDDDDD, 4'b0110));
        peek(6'd10, h, l);
        chk("R4 store hi", h, mk_hi(20'h12345, 6'd3));
        chk("R4 store lo", l, mk_lo(20'hAAAAA, 4'b0110));

        // R6 R7 lookup vectors
        foreach (LVEC[i]) begin
            wr_reg(R_HI, mk_hi(LVEC[i][57:38], LVEC[i][37:32]));
            cmd(1, 0, 0, 0);
            rd_reg(R_SLOT, v);
            chk(LVEC[i][63-32] ? "R7 lookup miss" : "R6 lookup hit", v, LVEC[i][31:0]);
        end

        // R11 associative compare, entry-high holds pid 3
        xl_vpn = 20'h12345; #1;
        chk("R11 pid", {26'b0, cur_pid}, 32'd3);
        chk("R11 hit", {31'b0, xl_hit}, 32'd1);
        chk("R11 slot", {26'b0, xl_hit_slot}, 32'd10);
        chk("R11 lo", xl_hit_lo, mk_lo(20'hAAAAA, 4'b0110));
        xl_vpn = 20'h0BEEF; #1;
        chk("R11 global slot", {26'b0, xl_hit_slot}, 32'd20);
        chk("R11 global lo", xl_hit_lo, mk_lo(20'hBBBBB, 4'b0011));
        xl_vpn = 20'h12346; #1;
        chk("R11 miss", {31'b0, xl_hit}, 32'd0);
        @(negedge clk);

        // R8 fetch
        wr_reg(R_SLOT, 32'd40);
        cmd(0, 1, 0, 0);
        rd_reg(R_HI, v); chk("R8 fetch hi", v, mk_hi(20'h0BEEF, 6'd9));
        rd_reg(R_LO, v); chk("R8 fetch lo", v, mk_lo(20'hDDDDD, 4'b0110));

        // R9 all four strobes: only lookup
        wr_reg(R_SLOT, 32'd0);
        wr_reg(R_HI, mk_hi(20'h12345, 6'd7));
        wr_reg(R_LO, 32'hDEAD_0000);
        cmd(1, 1, 1, 1);
        rd_reg(R_SLOT, v); chk("R9 lookup ran", v, 32'd30);
        rd_reg(R_LO, v);   chk("R9 fetch blocked", v, 32'hDEAD_0000);
        peek(6'd30, h, l); chk("R9 store blocked", l, mk_lo(20'hCCCCC, 4'b1010));

        // R9 fetch over stores
        rd_reg(R_REPL, v); r = v[5:0];
        peek(r, h0, l0);
        cmd(0, 1, 1, 1);
        rd_reg(R_LO, v);   chk("R9 fetch ran", v, mk_lo(20'hCCCCC, 4'b1010));
        peek(6'd30, h, l); chk("R9 selected store blocked", l, mk_lo(20'hCCCCC, 4'b1010));
        peek(r, h, l);     chk("R9 replacement blocked", l, l0);

        // R9 selected store over replacement store (slot 5 is never a replacement target)
        wr_reg(R_SLOT, 32'd5);
        wr_reg(R_HI, mk_hi(20'h77777, 6'd1));
        wr_reg(R_LO, mk_lo(20'h33333, 4'b0100));
        rd_reg(R_REPL, v); r = v[5:0];
        peek(r, h0, l0);
        cmd(0, 0, 1, 1);
        peek(6'd5, h, l); chk("R9 selected store ran", h, mk_hi(20'h77777, 6'd1));
        peek(r, h, l);    chk("R9 replacement dropped", h, h0);

        // R10 fetch wins over register write of entry-high
        reg_we = 1'b1; reg_sel = R_HI; reg_wdata = 32'h1111_1000;
        cmd(0, 1, 0, 0);
        reg_we = 1'b0;
        rd_reg(R_HI, v); chk("R10 command wins", v, mk_hi(20'h77777, 6'd1));

        // R12 translator write port
        xl_wr_en = 1'b1; xl_wr_slot = 6'd61; xl_wr_hi = 32'hCAFE_0040; xl_wr_lo = 32'h0BAD_0200;
        @(negedge clk);
        xl_wr_en = 1'b0;
        peek(6'd61, h, l);
        chk("R12 translator write hi", h, 32'hCAFE_0040);
        chk("R12 translator write lo", l, 32'h0BAD_0200);
        peek(6'd60, h0, l0);
        xl_wr_en = 1'b1; xl_wr_slot = 6'd60; xl_wr_hi = 32'hFACE_0000; xl_wr_lo = 32'hFFFF_FFFF;
        cmd(0, 0, 1, 0);
        xl_wr_en = 1'b0;
        peek(6'd60, h, l); chk("R12 translator write dropped", h, h0);

        // R5 replacement store target
        wr_reg(R_HI, mk_hi(20'h4242A, 6'd2));
        wr_reg(R_LO, mk_lo(20'h99999, 4'b0010));
        rd_reg(R_REPL, v); r = v[5:0];
        cmd(0, 0, 0, 1);
        peek(r, h, l);
        chk("R5 replacement hi", h, mk_hi(20'h4242A, 6'd2));
        chk("R5 replacement lo", l, mk_lo(20'h99999, 4'b0010));

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule